// File: doc/BRIEF.md
# Bit Manipulation Execution Unit

This block is a purely combinational datapath for a scalar execution pipe. It takes an operation code and two source words, and in the same cycle it returns a result word plus a zero indication and a carry indication. The operation code selects one of several bit-level operations:

- an inverted-operand AND
- a packed-control field extract
- three operations on the lowest set bit
- clearing of high bits from an index
- scatter and gather of bits under a mask
- counts of leading and trailing zeros

The word width `W` is a parameter and may be 32 or 64; any other value stops elaboration. The first source `src_a` always carries the data. The second source `src_b` carries the per-operation operand: the inverted term, the packed field control, the index, or the mask. The surrounding pipeline registers both the inputs and the outputs. The unit itself holds no state.

Top module: `bitmanip_unit`

## Requirements
- R1: Op code 0 returns `src_a & ~src_b`.
- R2: Op code 1 extracts a field from `src_a`. The start position is `src_b[7:0]` and the length is `src_b[15:8]`. The selected bits are returned right-aligned and zero-filled above.
- R3: In op 1, source bits at or beyond position W read as zero. A length of 0 gives 0, and a length at or above W takes every remaining bit.
- R4: Op code 2 returns a word whose only set bit is the lowest set bit of `src_a`. It returns 0 when `src_a` is 0.
- R5: Op code 3 sets the lowest set bit of `src_a` and every bit below it, and clears all others. It returns all ones when `src_a` is 0.
- R6: Op code 4 returns `src_a` with only its lowest set bit cleared.
- R7: Op code 5 clears every bit of `src_a` at or above index `src_b[7:0]`. An index at or above W returns `src_a` unchanged and sets carry.
- R8: Op code 8 returns the number of zero bits above the highest set bit of `src_a`.
- R9: Op code 9 returns the number of zero bits below the lowest set bit of `src_a`.
- R10: For ops 8 and 9, a zero `src_a` returns W and sets carry. For ops 2, 3 and 4, carry is set exactly when `src_a` is 0.
- R11: Op code 6 places the low-order bits of `src_a`, in order, at the set bit positions of mask `src_b`. All other result bits are 0.
- R12: Op code 7 takes the bits of `src_a` at the set positions of mask `src_b` and packs them, in order, into the low-order result bits. All higher result bits are 0.
- R13: `zero_flag` is 1 exactly when the result is 0. Carry is 0 for ops 0, 1, 6 and 7. Op codes 10 to 15 return 0 with carry 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (see requirements) |
| src_a | input | W | Data operand |
| src_b | input | W | Second operand: inverted term, field control, index or mask |
| result | output | W | Operation result |
| zero_flag | output | 1 | Result is zero |
| carry_flag | output | 1 | Zero source for count and lowest-bit ops; index out of range for op 5 |

## Verification
The unit holds no state, so a wrong internal value shows up in the same cycle. It appears as a wrong result or a wrong flag, and only for the operation codes that route through the faulty path.

The mask scatter and gather depend on a running count of set mask bits. An error in that count shifts or drops bits only above the first faulty position. For that reason, random mask and operand pairs are compared against a loop-based model, in addition to the sparse directed masks.

The zero-source cases for the two counts and for the lowest-bit ops are driven directly. Off-by-one errors there would change only the carry output or the all-ones and W values.

// File: rtl/bitmanip_pkg.sv
package bitmanip_pkg;

   typedef enum logic [3:0] {
      OP_ANDN = 4'd0,
      OP_FEXT = 4'd1,
      OP_ISOL = 4'd2,
      OP_MSKL = 4'd3,
      OP_RSTL = 4'd4,
      OP_ZHI  = 4'd5,
      OP_DEP  = 4'd6,
      OP_EXT  = 4'd7,
      OP_LZC  = 4'd8,
      OP_TZC  = 4'd9
   } bm_op_e;

   localparam int unsigned CTL_FIELD_W = 8;

endpackage

// File: rtl/bm_field.sv
module bm_field
   import bitmanip_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] data,
   input  logic [W-1:0] ctl,
   output logic [W-1:0] fext,
   output logic [W-1:0] zhi,
   output logic         zhi_wide
);
   localparam logic [CTL_FIELD_W-1:0] WL = CTL_FIELD_W'(W);

   logic [CTL_FIELD_W-1:0] start_pos;
   logic [CTL_FIELD_W-1:0] field_len;
   logic [CTL_FIELD_W-1:0] hi_idx;
   logic [W-1:0]           shifted;
   logic [W-1:0]           len_mask;

   assign start_pos = ctl[CTL_FIELD_W-1:0];
   assign field_len = ctl[2*CTL_FIELD_W-1:CTL_FIELD_W];
   assign hi_idx    = ctl[CTL_FIELD_W-1:0];

   always_comb begin
      if (start_pos >= WL) shifted = '0;
      else                 shifted = data >> start_pos;
      if (field_len >= WL) len_mask = '1;
      else                 len_mask = ~({W{1'b1}} << field_len);
      fext = shifted & len_mask;
   end

   always_comb begin
      zhi_wide = (hi_idx >= WL);
      if (zhi_wide) zhi = data;
      else          zhi = data & ~({W{1'b1}} << hi_idx);
   end

   always_comb begin
      if (field_len < WL)
         assert_fext_len_R3: assert ((fext >> field_len) == '0);
      assert_zhi_subset_R7: assert ((zhi & ~data) == '0);
   end

endmodule

// File: rtl/bm_lowbit.sv
module bm_lowbit #(
   parameter int unsigned W  = 32,
   parameter int unsigned CW = $clog2(W) + 1
) (
   input  logic [W-1:0]  data,
   output logic [W-1:0]  isol,
   output logic [W-1:0]  mskl,
   output logic [W-1:0]  rstl,
   output logic [CW-1:0] tzc,
   output logic          is_zero
);
   logic [W-1:0] dec;

   assign dec     = data - W'(1);
   assign isol    = data & ~dec;
   assign mskl    = data ^ dec;
   assign rstl    = data & dec;
   assign is_zero = (data == '0);

   always_comb begin
      tzc = CW'(W);
      for (int i = W - 1; i >= 0; i--) begin
         if (data[i]) tzc = CW'(i);
      end
   end

   always_comb begin
      assert_isol_onehot_R4: assert ($onehot0(isol));
      assert_rstl_split_R6: assert (((isol | rstl) == data) && ((isol & rstl) == '0));
      if (!is_zero)
         assert_tzc_hit_R9: assert (data[tzc[CW-2:0]]);
   end

endmodule

// File: rtl/bm_lzc.sv
module bm_lzc #(
   parameter int unsigned W  = 32,
   parameter int unsigned CW = $clog2(W) + 1
) (
   input  logic [W-1:0]  data,
   output logic [CW-1:0] lzc
);
   always_comb begin
      lzc = CW'(W);
      for (int i = 0; i < W; i++) begin
         if (data[i]) lzc = CW'(W - 1 - i);
      end
   end

   always_comb begin
      if (data != '0)
         assert_lzc_top_R8: assert ((data >> (CW'(W - 1) - lzc)) == W'(1));
   end

endmodule

// File: rtl/bm_scatter.sv
module bm_scatter #(
   parameter int unsigned W  = 32,
   parameter int unsigned CW = $clog2(W) + 1,
   parameter int unsigned LW = $clog2(W)
) (
   input  logic [W-1:0] src,
   input  logic [W-1:0] mask,
   output logic [W-1:0] dep,
   output logic [W-1:0] ext
);
   logic [CW-1:0] rank [W+1];

   assign rank[0] = '0;

   for (genvar i = 0; i < W; i++) begin : g_rank
      assign rank[i+1] = rank[i] + CW'(mask[i]);
      assign dep[i]    = mask[i] & src[rank[i][LW-1:0]];
   end

   always_comb begin
      ext = '0;
      for (int i = 0; i < W; i++) begin
         if (mask[i]) ext[rank[i][LW-1:0]] = src[i];
      end
   end

   always_comb begin
      assert_dep_in_mask_R11: assert ((dep & ~mask) == '0);
      assert_ext_popcount_R12: assert ($countones(ext) == $countones(src & mask));
   end

endmodule

// File: rtl/bitmanip_unit.sv
module bitmanip_unit
   import bitmanip_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic [3:0]   op_sel,
   input  logic [W-1:0] src_a,
   input  logic [W-1:0] src_b,
   output logic [W-1:0] result,
   output logic         zero_flag,
   output logic         carry_flag
);
   localparam int unsigned CW = $clog2(W) + 1;

   if (!(W == 32 || W == 64)) begin : g_bad_width
      $error("bitmanip_unit: W must be 32 or 64");
   end

   logic [W-1:0]  fext_w, zhi_w, isol_w, mskl_w, rstl_w, dep_w, ext_w;
   logic [CW-1:0] tzc_w, lzc_w;
   logic          zhi_wide_w, a_zero_w;
   bm_op_e        op;

   assign op = bm_op_e'(op_sel);

   bm_field #(.W(W)) u_field (
      .data(src_a), .ctl(src_b), .fext(fext_w), .zhi(zhi_w), .zhi_wide(zhi_wide_w)
   );

   bm_lowbit #(.W(W), .CW(CW)) u_lowbit (
      .data(src_a), .isol(isol_w), .mskl(mskl_w), .rstl(rstl_w),
      .tzc(tzc_w), .is_zero(a_zero_w)
   );

   bm_lzc #(.W(W), .CW(CW)) u_lzc (
      .data(src_a), .lzc(lzc_w)
   );

   bm_scatter #(.W(W)) u_scatter (
      .src(src_a), .mask(src_b), .dep(dep_w), .ext(ext_w)
   );

   always_comb begin
      result     = '0;
      carry_flag = 1'b0;
      case (op)
         OP_ANDN: result = src_a & ~src_b;
         OP_FEXT: result = fext_w;
         OP_ISOL: begin result = isol_w; carry_flag = a_zero_w; end
         OP_MSKL: begin result = mskl_w; carry_flag = a_zero_w; end
         OP_RSTL: begin result = rstl_w; carry_flag = a_zero_w; end
         OP_ZHI:  begin result = zhi_w;  carry_flag = zhi_wide_w; end
         OP_DEP:  result = dep_w;
         OP_EXT:  result = ext_w;
         OP_LZC:  begin result = W'(lzc_w); carry_flag = a_zero_w; end
         OP_TZC:  begin result = W'(tzc_w); carry_flag = a_zero_w; end
         default: ;
      endcase
      zero_flag = (result == '0);
   end

   always_comb begin
      if ((op == OP_LZC || op == OP_TZC) && carry_flag)
         assert_count_full_R10: assert (result == W'(W));
      if (op == OP_MSKL && carry_flag)
         assert_mskl_ones_R5: assert (result == '1);
      assert_zero_flag_R13: assert (zero_flag == (result == '0));
   end

endmodule

// File: tb/bitmanip_unit_tb.sv
module bitmanip_unit_tb;
   localparam int unsigned W = 32;

   logic         clk = 1'b0;
   logic [3:0]   op_sel;
   logic [W-1:0] src_a, src_b;
   logic [W-1:0] result;
   logic         zero_flag, carry_flag;
   int           n_checks = 0;
   int           n_errors = 0;

   always #5 clk = ~clk;

   bitmanip_unit #(.W(W)) u_dut (
      .op_sel(op_sel), .src_a(src_a), .src_b(src_b),
      .result(result), .zero_flag(zero_flag), .carry_flag(carry_flag)
   );

   function automatic string req_of(input logic [3:0] op);
      case (op)
         4'd0: return "R1";
         4'd1: return "R2";
         4'd2: return "R4";
         4'd3: return "R5";
         4'd4: return "R6";
         4'd5: return "R7";
         4'd6: return "R11";
         4'd7: return "R12";
         4'd8: return "R8";
         4'd9: return "R9";
         default: return "R13";
      endcase
   endfunction

   task automatic model(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                        output logic [W-1:0] r, output logic c);
      int k, st, ln;
      r = '0; c = 1'b0;
      case (op)
         4'd0: r = a & ~b;
         4'd1: begin
            st = int'(b[7:0]); ln = int'(b[15:8]);
            for (int i = 0; i < ln && i < W; i++)
               if (st + i < W) r[i] = a[st+i];
         end
         4'd2: begin
            for (int i = 0; i < W; i++) if (a[i]) begin r[i] = 1'b1; break; end
            c = (a == '0);
         end
         4'd3: begin
            r = '1;
            for (int i = 0; i < W; i++) if (a[i]) begin
               r = '0;
               for (int j = 0; j <= i; j++) r[j] = 1'b1;
               break;
            end
            c = (a == '0);
         end
         4'd4: begin
            r = a;
            for (int i = 0; i < W; i++) if (a[i]) begin r[i] = 1'b0; break; end
            c = (a == '0);
         end
         4'd5: begin
            st = int'(b[7:0]);
            for (int i = 0; i < W; i++) r[i] = (i < st) ? a[i] : 1'b0;
            c = (st >= W);
         end
         4'd6: begin
            k = 0;
            for (int i = 0; i < W; i++) if (b[i]) begin r[i] = a[k]; k++; end
         end
         4'd7: begin
            k = 0;
            for (int i = 0; i < W; i++) if (b[i]) begin r[k] = a[i]; k++; end
         end
         4'd8: begin
            k = 0;
            for (int i = W - 1; i >= 0; i--) begin if (a[i]) break; k++; end
            r = W'(k); c = (a == '0);
         end
         4'd9: begin
            k = 0;
            for (int i = 0; i < W; i++) begin if (a[i]) break; k++; end
            r = W'(k); c = (a == '0);
         end
         default: ;
      endcase
   endtask

   task automatic apply(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                        input string tag);
      logic [W-1:0] er;
      logic         ec;
      @(negedge clk);
      op_sel = op; src_a = a; src_b = b;
      #2;
      model(op, a, b, er, ec);
      n_checks++;
      if (result !== er || zero_flag !== (er == '0) || carry_flag !== ec) begin
         n_errors++;
         $display("FAIL %s op=%0d a=%h b=%h actual r=%h z=%b c=%b expected r=%h z=%b c=%b",
                  tag, op, a, b, result, zero_flag, carry_flag, er, (er == '0), ec);
      end
   endtask

   task automatic expect_lit(input logic [W-1:0] exp_r, input logic exp_c, input string tag);
      n_checks++;
      if (result !== exp_r || carry_flag !== exp_c) begin
         n_errors++;
         $display("FAIL %s actual r=%h c=%b expected r=%h c=%b", tag, result, carry_flag, exp_r, exp_c);
      end
   endtask

   initial begin
      #1000000;
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      op_sel = '0; src_a = '0; src_b = '0;
      #3;
      n_checks++;
      if (result !== '0 || zero_flag !== 1'b1 || carry_flag !== 1'b0) begin
         n_errors++;
         $display("FAIL R13 idle actual r=%h z=%b c=%b expected r=0 z=1 c=0", result, zero_flag, carry_flag);
      end

      apply(4'd0, 32'hF0F0_F0F0, 32'hFF00_FF00, "R1");  expect_lit(32'h00F0_00F0, 1'b0, "R1");
      apply(4'd1, 32'h1234_5678, 32'h0000_0804, "R2");  expect_lit(32'h0000_0067, 1'b0, "R2");
      apply(4'd1, 32'h1234_5678, 32'h0000_081C, "R3");  expect_lit(32'h0000_0001, 1'b0, "R3");
      apply(4'd1, 32'h1234_5678, 32'h0000_0004, "R3");  expect_lit(32'h0, 1'b0, "R3");
      apply(4'd1, 32'h1234_5678, 32'h0000_2828, "R3");  expect_lit(32'h0, 1'b0, "R3");
      apply(4'd1, 32'h1234_5678, 32'h0000_2800, "R3");  expect_lit(32'h1234_5678, 1'b0, "R3");
      apply(4'd2, 32'h0000_0A80, 32'h0, "R4");          expect_lit(32'h80, 1'b0, "R4");
      apply(4'd2, 32'h0, 32'h0, "R10");                 expect_lit(32'h0, 1'b1, "R10");
      apply(4'd3, 32'h0000_0A80, 32'h0, "R5");          expect_lit(32'hFF, 1'b0, "R5");
      apply(4'd3, 32'h0, 32'h0, "R5");                  expect_lit(32'hFFFF_FFFF, 1'b1, "R5");
      apply(4'd4, 32'h0000_0A80, 32'h0, "R6");          expect_lit(32'hA00, 1'b0, "R6");
      apply(4'd4, 32'h8000_0000, 32'h0, "R6");          expect_lit(32'h0, 1'b0, "R6");
      apply(4'd5, 32'hFFFF_FFFF, 32'd12, "R7");         expect_lit(32'hFFF, 1'b0, "R7");
      apply(4'd5, 32'hDEAD_BEEF, 32'd32, "R7");         expect_lit(32'hDEAD_BEEF, 1'b1, "R7");
      apply(4'd5, 32'hDEAD_BEEF, 32'd0, "R7");          expect_lit(32'h0, 1'b0, "R7");
      apply(4'd8, 32'h0001_0000, 32'h0, "R8");          expect_lit(32'd15, 1'b0, "R8");
      apply(4'd8, 32'h8000_0000, 32'h0, "R8");          expect_lit(32'd0, 1'b0, "R8");
      apply(4'd8, 32'h0, 32'h0, "R10");                 expect_lit(32'd32, 1'b1, "R10");
      apply(4'd9, 32'h0001_0000, 32'h0, "R9");          expect_lit(32'd16, 1'b0, "R9");
      apply(4'd9, 32'h0, 32'h0, "R10");                 expect_lit(32'd32, 1'b1, "R10");
      apply(4'd6, 32'h0000_0005, 32'h0000_00F0, "R11"); expect_lit(32'h50, 1'b0, "R11");
      apply(4'd6, 32'hFFFF_FFFF, 32'h8000_0001, "R11"); expect_lit(32'h8000_0001, 1'b0, "R11");
      apply(4'd7, 32'h0000_0050, 32'h0000_00F0, "R12"); expect_lit(32'h5, 1'b0, "R12");
      apply(4'd7, 32'h8000_0000, 32'h8000_0001, "R12"); expect_lit(32'h2, 1'b0, "R12");
      apply(4'd12, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R13"); expect_lit(32'h0, 1'b0, "R13");

      for (int n = 0; n < 600; n++) begin
         logic [3:0]   op;
         logic [W-1:0] a, b;
         op = 4'($urandom_range(0, 15));
         a  = $urandom;
         b  = $urandom;
         if (n % 7 == 0) a = a & $urandom & $urandom;
         if (op == 4'd1 || op == 4'd5) b = {16'h0, 8'($urandom_range(0, 40)), 8'($urandom_range(0, 40))};
         apply(op, a, b, req_of(op));
      end

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule